// File: doc/BRIEF.md
# Single-Wire Bus Transaction Sequencer

This block runs complete host transactions on a single-wire serial bus. It has no bit timing of its own. It orders requests to three lower engines: a break generator, a byte transmitter and a byte receiver. Each of these answers with a one-cycle acknowledge.

A requester hands over one command. The command holds the 16-bit instruction frame, the direction, a read length, a flag that asks for a trailing check byte, and two write data bytes. The sequencer then runs these steps in order:

1. It sends a break.
2. It sends the frame, low byte first.
3. It sends the two write bytes, or it reads the requested number of bytes.

After a successful write the sequencer holds the bus quiet for a fixed window, so the device can finish its non-volatile update. An error reported by any byte engine ends the transaction at once. The error is reported with the completion pulse.

While a transaction is open, `in_txn` stays high. A receiver-side detector of unsolicited breaks can use it to tell bus traffic that the sequencer expects from traffic that it does not.

Top module: `sw_txn_seq`

## Requirements
- R1: A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when no transaction is open. Command inputs are ignored while a transaction runs. `in_txn` is high from the cycle after acceptance through the completion cycle.
- R2: Every transaction starts with exactly one break request. No byte request is raised before `brk_done`.
- R3: The frame is sent as two bytes: first `cmd_frame[7:0]`, then `cmd_frame[15:8]`.
- R4: A write (`cmd_rd`=0) sends exactly two data bytes after the frame: first `cmd_wdata[7:0]`, then `cmd_wdata[15:8]`.
- R5: After the acknowledge of the last write byte, the block raises no request for QUIET_CYCLES cycles. `done` pulses exactly QUIET_CYCLES+1 cycles after that acknowledge cycle.
- R6: A read (`cmd_rd`=1) performs N byte reads. N is computed as follows:
  - `cmd_len` 0 gives N = 1.
  - `cmd_len` above MAX_RD gives N = MAX_RD.
  - Any other value gives N = `cmd_len`.
  - If `cmd_crc` is set, one more byte is read.
- R7: Each read byte without error appears on `rd_data`, with `rd_valid` high for one cycle. This happens the cycle after its receiver acknowledge, and the bytes come in the order received.
- R8: An acknowledge with its error flag set aborts the transaction:
  - No further request is raised and no quiet window is applied.
  - `done` pulses the next cycle with `err` high.
  - The failed read byte is not presented.
- R9: `done` is a single-cycle pulse. `err` is low with `done` for a transaction in which no engine reported an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_frame | input | 16 | Instruction frame |
| cmd_rd | input | 1 | 1 = read transaction, 0 = write |
| cmd_crc | input | 1 | Read one extra trailing check byte |
| cmd_len | input | 5 | Requested read length in bytes |
| cmd_wdata | input | 16 | Write bytes: [7:0] even address, [15:8] odd address |
| brk_req | output | 1 | Request a regular break |
| brk_done | input | 1 | Break finished (one-cycle pulse) |
| tx_req | output | 1 | Request transmission of `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| tx_ack | input | 1 | Byte transmitted (one-cycle pulse) |
| tx_err | input | 1 | Bus error on the acknowledged byte |
| rx_req | output | 1 | Request one byte read |
| rx_ack | input | 1 | Byte received (one-cycle pulse) |
| rx_err | input | 1 | Error on the acknowledged read |
| rx_byte | input | 8 | Received byte, valid with `rx_ack` |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| in_txn | output | 1 | Transaction open |
| done | output | 1 | Transaction complete (pulse) |
| err | output | 1 | Transaction aborted, valid with `done` |

## Verification
A read byte is due on `rd_data` exactly one cycle after its receiver acknowledge. The scoreboard pops it only when `rd_valid` is sampled at the falling edge, so the data is compared in the cycle it is due.

The completion pulse is due at two fixed points:
- After an abort or after the last read, it follows the acknowledge by exactly one cycle.
- After a write, it follows the last write acknowledge by QUIET_CYCLES+1 cycles. The bench timestamps both events against a free-running cycle count and compares the difference with that exact figure.

Engine requests are compared in order against an expected event queue, and each request is answered after a fixed latency. Any extra, missing or reordered break or byte therefore shows up as a miscompare.

// File: rtl/sw_txn_seq.sv
module sw_txn_seq #(
  parameter int MAX_RD       = 16,
  parameter int QUIET_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [15:0] cmd_frame,
  input  logic        cmd_rd,
  input  logic        cmd_crc,
  input  logic [4:0]  cmd_len,
  input  logic [15:0] cmd_wdata,
  output logic        brk_req,
  input  logic        brk_done,
  output logic        tx_req,
  output logic [7:0]  tx_byte,
  input  logic        tx_ack,
  input  logic        tx_err,
  output logic        rx_req,
  input  logic        rx_ack,
  input  logic        rx_err,
  input  logic [7:0]  rx_byte,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        in_txn,
  output logic        done,
  output logic        err
);
  localparam int LW = $clog2(MAX_RD + 2);
  localparam int QW = $clog2(QUIET_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_BREAK, S_FRM_LO, S_FRM_HI, S_WR, S_RD, S_QUIET, S_DONE
  } st_t;

  st_t         st;
  logic [15:0] frame_q, wdata_q;
  logic        rd_q, wr_idx, err_q, rdv_q;
  logic [7:0]  rdd_q;
  logic [LW-1:0] rd_left, eff_len;
  logic [QW-1:0] qcnt;

  always_comb begin
    if (cmd_len == 5'd0)                   eff_len = LW'(1);
    else if (int'(cmd_len) > MAX_RD)       eff_len = LW'(MAX_RD);
    else                                   eff_len = LW'(cmd_len);
  end

  assign cmd_ready = (st == S_IDLE);
  assign in_txn    = (st != S_IDLE);
  assign brk_req   = (st == S_BREAK);
  assign tx_req    = (st == S_FRM_LO) || (st == S_FRM_HI) || (st == S_WR);
  assign rx_req    = (st == S_RD);
  assign done      = (st == S_DONE);
  assign err       = done && err_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  always_comb begin
    case (st)
      S_FRM_LO: tx_byte = frame_q[7:0];
      S_FRM_HI: tx_byte = frame_q[15:8];
      S_WR:     tx_byte = wr_idx ? wdata_q[15:8] : wdata_q[7:0];
      default:  tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frame_q <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
      wr_idx  <= 1'b0;
      err_q   <= 1'b0;
      rd_left <= '0;
      qcnt    <= '0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      rdv_q <= (st == S_RD) && rx_ack && !rx_err;
      if ((st == S_RD) && rx_ack) rdd_q <= rx_byte;
      case (st)
        S_IDLE: if (cmd_valid) begin
          frame_q <= cmd_frame;
          wdata_q <= cmd_wdata;
          rd_q    <= cmd_rd;
          rd_left <= eff_len + LW'(cmd_crc);
          err_q   <= 1'b0;
          st      <= S_BREAK;
        end
        S_BREAK: if (brk_done) st <= S_FRM_LO;
        S_FRM_LO: if (tx_ack) begin
          if (tx_err) begin err_q <= 1'b1; st <= S_DONE; end
          else st <= S_FRM_HI;
        end
        S_FRM_HI: if (tx_ack) begin
          wr_idx <= 1'b0;
          if (tx_err) begin err_q <= 1'b1; st <= S_DONE; end
          else st <= rd_q ? S_RD : S_WR;
        end
        S_WR: if (tx_ack) begin
          if (tx_err) begin err_q <= 1'b1; st <= S_DONE; end
          else if (wr_idx) begin qcnt <= '0; st <= S_QUIET; end
          else wr_idx <= 1'b1;
        end
        S_RD: if (rx_ack) begin
          if (rx_err) begin err_q <= 1'b1; st <= S_DONE; end
          else begin
            rd_left <= rd_left - LW'(1);
            if (rd_left == LW'(1)) st <= S_DONE;
          end
        end
        S_QUIET: begin
          if (qcnt == QW'(QUIET_CYCLES - 1)) st <= S_DONE;
          else qcnt <= qcnt + QW'(1);
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sw_txn_seq_chk.sv
module sw_txn_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic in_txn,
  input logic brk_req,
  input logic tx_req,
  input logic rx_req,
  input logic rd_valid,
  input logic done,
  input logic err
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == !in_txn); // R1
  AST_TXN_STARTS_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_txn) |-> brk_req); // R2
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_req, tx_req, rx_req})); // R2
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !in_txn |-> !(brk_req || tx_req || rx_req)); // R1
  AST_RDV_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> in_txn); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R9
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(brk_req || tx_req || rx_req)); // R8
endmodule

bind sw_txn_seq sw_txn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .in_txn(in_txn),
  .brk_req(brk_req), .tx_req(tx_req), .rx_req(rx_req),
  .rd_valid(rd_valid), .done(done), .err(err)
);

// File: tb/sw_txn_seq_tb.sv
module sw_txn_seq_tb;
  localparam int QUIET = 40;
  localparam int MAXR  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rd = 1'b0, cmd_crc = 1'b0;
  logic [15:0] cmd_frame = '0, cmd_wdata = '0;
  logic [4:0] cmd_len = '0;
  logic cmd_ready, brk_req, tx_req, rx_req, rd_valid, in_txn, done, err;
  logic [7:0] tx_byte, rd_data;
  logic brk_done = 1'b0, tx_ack = 1'b0, tx_err = 1'b0;
  logic rx_ack = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_byte = '0;

  always #4 clk = ~clk;

  sw_txn_seq #(.MAX_RD(MAXR), .QUIET_CYCLES(QUIET)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_frame(cmd_frame), .cmd_rd(cmd_rd), .cmd_crc(cmd_crc), .cmd_len(cmd_len),
    .cmd_wdata(cmd_wdata), .brk_req(brk_req), .brk_done(brk_done),
    .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack), .tx_err(tx_err),
    .rx_req(rx_req), .rx_ack(rx_ack), .rx_err(rx_err), .rx_byte(rx_byte),
    .rd_valid(rd_valid), .rd_data(rd_data), .in_txn(in_txn), .done(done), .err(err));

  int n_chk = 0, n_fail = 0, cyc = 0, last_ack = 0;
  int err_at = -1, evidx = 0, ecnt = 0;
  logic [9:0] ev_q[$];
  logic [7:0] rd_q[$];

  function automatic logic [7:0] rx_pat(int idx);
    return 8'h5A ^ 8'(idx * 29);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // byte engine model: answers each request after a fixed latency
  always @(posedge clk) begin
    if (brk_done || tx_ack || rx_ack) begin
      brk_done <= 1'b0; tx_ack <= 1'b0; rx_ack <= 1'b0;
      tx_err <= 1'b0; rx_err <= 1'b0; ecnt <= 0;
    end else if (!in_txn) begin
      evidx <= 0; ecnt <= 0;
    end else if (brk_req || tx_req || rx_req) begin
      if (ecnt == 2) begin
        ecnt <= 0;
        if (brk_req) brk_done <= 1'b1;
        else begin
          evidx <= evidx + 1;
          if (tx_req) begin tx_ack <= 1'b1; tx_err <= (evidx == err_at); end
          else begin
            rx_ack <= 1'b1; rx_err <= (evidx == err_at); rx_byte <= rx_pat(evidx);
          end
        end
      end else ecnt <= ecnt + 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (brk_done || tx_ack || rx_ack) begin
        logic [9:0] got, exp;
        got = brk_done ? 10'h100 : tx_ack ? {2'b00, tx_byte} : 10'h200;
        exp = (ev_q.size() > 0) ? ev_q.pop_front() : 10'h3FF;
        chk(got == exp, "R2/R3/R4/R6 event order", int'(got), int'(exp));
        if (tx_ack) last_ack = cyc;
        if (rx_ack) last_ack = cyc;
      end
      if (rd_valid) begin
        logic [7:0] e;
        e = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hXX;
        chk(rd_data === e, "R7 read data", int'(rd_data), int'(e));
      end
    end
  end

  task automatic run(input logic [15:0] fr, input bit rd, input bit crc,
                     input int len, input logic [15:0] wd, input int ea,
                     input bit hold, input string tag);
    int nb, i, wait_exp;
    bit expect_err;
    err_at = ea;
    ev_q.push_back(10'h100);
    ev_q.push_back({2'b00, fr[7:0]});
    ev_q.push_back({2'b00, fr[15:8]});
    if (rd) begin
      nb = (len == 0) ? 1 : (len > MAXR ? MAXR : len);
      nb += crc;
      for (int k = 0; k < nb; k++) begin
        if (ea >= 0 && k + 2 > ea) break;
        ev_q.push_back(10'h200);
        if (k + 2 != ea) rd_q.push_back(rx_pat(k + 2));
      end
    end else begin
      if (!(ea >= 0 && ea < 2)) ev_q.push_back({2'b00, wd[7:0]});
      if (!(ea >= 0 && ea < 3)) ev_q.push_back({2'b00, wd[15:8]});
    end
    expect_err = (ea >= 0);
    wait_exp = (!rd && !expect_err) ? QUIET + 1 : 1;
    cmd_frame = fr; cmd_rd = rd; cmd_crc = crc; cmd_len = 5'(len); cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    chk(in_txn == 1'b1, {"R1 in_txn after accept ", tag}, in_txn, 1);
    if (hold) begin
      cmd_frame = 16'hFFFF; cmd_wdata = 16'h0000; cmd_rd = ~rd;
      for (int k = 0; k < 6; k++) begin
        chk(cmd_ready == 1'b0, {"R1 busy ready ", tag}, cmd_ready, 0);
        @(negedge clk);
      end
    end
    cmd_valid = 1'b0;
    i = 0;
    while (!done && i < 2000) begin @(negedge clk); i++; end
    chk(done == 1'b1, {"R9 done seen ", tag}, done, 1);
    chk(err == expect_err, {"R8/R9 err ", tag}, err, expect_err);
    chk(cyc - last_ack == wait_exp, {"R5/R8 done latency ", tag}, cyc - last_ack, wait_exp);
    @(negedge clk);
    chk(done == 1'b0 && in_txn == 1'b0, {"R9 done pulse ", tag}, done, 0);
    chk(ev_q.size() == 0 && rd_q.size() == 0, {"R6/R7 leftovers ", tag},
        ev_q.size() + rd_q.size(), 0);
    ev_q.delete(); rd_q.delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !in_txn && !done && !rd_valid && !brk_req && !tx_req && !rx_req,
        "R1 reset state", {cmd_ready, in_txn, done}, 3'b100);
    run(16'h2410, 0, 0, 0, 16'hBEEF, -1, 0, "R4 R5 write");
    run(16'h2212, 1, 0, 2, 16'h0, -1, 0, "R6 read2");
    run(16'h2216, 1, 1, 3, 16'h0, -1, 0, "R6 read3 crc");
    run(16'h2012, 1, 0, 0, 16'h0, -1, 0, "R6 len0");
    run(16'h3016, 1, 1, 20, 16'h0, -1, 0, "R6 len20 crc");
    run(16'h5A81, 0, 0, 0, 16'h1234, 1, 0, "R8 frame hi err");
    run(16'h2410, 0, 0, 0, 16'hC3A5, 3, 0, "R8 write byte err");
    run(16'h2212, 1, 0, 4, 16'h0, 3, 0, "R8 read err");
    run(16'h0E70, 0, 0, 0, 16'h55AA, -1, 1, "R1 busy ignore");
    run(16'h2216, 1, 0, 1, 16'h0, -1, 1, "R1 R7 busy read");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule